// File: doc/BRIEF.md
# Four-Bank SDRAM Device Model

This block is a synthesizable stand-in for a four-bank synchronous DRAM with a 64-bit data bus. It is sized so that its storage fits in on-chip RAM. It sits on the memory side of a controller under test. It takes one command per clock on a command/address port and keeps one open row for each bank. It moves data in fixed bursts of one word per cycle, and the columns within a burst are visited in a wrapping sequential order. It sets an error flag whenever the controller breaks the open-row rules. Analog effects, charge loss and retention timing are not modelled. A refresh row counter is kept and can be seen on a port.

Each command is sampled at a rising clock edge. An activate opens a row in a closed bank. Reads and writes work on the open row of the bank they name, and their auto-precharge forms close that bank when the burst completes. Precharge, precharge-all and refresh close rows. A read or write that is accepted while a burst is still running stops that burst at once, and the new burst takes over the data path.

Top module: `sdram_bank_model`

## Requirements
- R1: An activate (command code 1) to a closed bank opens the row given on `addr` in that bank. Each bank keeps its own open row, and reads and writes use the open row of the bank they name.
- R2: An activate to a bank that already has an open row raises `err` for one cycle, starting after the command edge. It leaves the open row of that bank unchanged.
- R3: Precharge (code 6) closes the named bank and leaves the other banks open. On a bank that is already closed it has no effect and raises no error. Precharge-all (code 7) closes every bank.
- R4: Refresh (code 8) closes every bank. It also advances `ref_row`, the next row to refresh, by one modulo the row count. `ref_row` wraps to 0 after the last row.
- R5: A read (code 2, 3 with write, 4 read-auto, 5 write-auto) to a closed bank raises `err` for one cycle. The command is ignored: no data moves and a burst already running is not disturbed.
- R6: `bl_code` sets the burst length when a read or write is accepted: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. A burst moves one word per cycle with no further command.
- R7: Beat k of a burst uses column (start with its low log2(BL) bits replaced by (start+k) mod BL). With BL=4 and start 6 the columns are 6, 7, 4, 5.
- R8: The first read beat is on `rdata` with `rvalid` high in the cycle after the third rising edge that follows the command edge. The remaining beats follow on consecutive cycles.
- R9: A write takes beat 0 from `wdata` in the command cycle and each later beat from `wdata` in the cycles after it. Only the bytes whose `wbe` bit is 1 are changed (bit i covers data bits 8i+7..8i).
- R10: Read-auto and write-auto close their bank once the final beat has been transferred. A following read to that bank raises `err`. A plain read or write leaves the row open.
- R11: A read or write that is accepted while a burst is running cuts that burst short. Its remaining read beats are never output and its remaining write beats are never stored. The new burst starts at once.
- R12: After reset all banks are closed, and `rvalid`, `err` and `ref_row` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 4 | Command code (0 idle, 1 activate, 2 read, 3 write, 4 read-auto, 5 write-auto, 6 precharge, 7 precharge-all, 8 refresh) |
| bank | input | 2 | Target bank |
| addr | input | 4 | Row for activate, start column for reads and writes |
| bl_code | input | 2 | Burst length select for reads and writes |
| wdata | input | 64 | Write data of the current write beat |
| wbe | input | 8 | Byte enables of the current write beat |
| rdata | output | 64 | Read data |
| rvalid | output | 1 | Read data valid |
| err | output | 1 | Protocol violation flag, one cycle per bad command |
| ref_row | output | 2 | Row that the next refresh will refresh |

## Verification
Reads are tried at every burst length, from start columns that are aligned and from start columns that are not. Together these separate a correct wrapping order from a plain incrementing one and from a reversed one. Pairs of bursts that overlap are driven to tell a true abort apart from a burst that finishes anyway: one read cut short by another read, one write cut short by another write, and one read followed by an illegal read that must not cut it. Writes are applied over known data, with full and partial byte enables. Bank state is probed through later reads: an error shows that a bank is closed, and the returned data shows which row is open. This separates precharge of one bank, precharge of all banks, refresh and the auto-precharge forms from each other.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_ACT  = 4'd1,
    C_RD   = 4'd2,
    C_WR   = 4'd3,
    C_RDA  = 4'd4,
    C_WRA  = 4'd5,
    C_PRE  = 4'd6,
    C_PALL = 4'd7,
    C_REF  = 4'd8
  } sdm_cmd_e;

  function automatic logic cmd_is_rw(sdm_cmd_e c);
    return (c == C_RD) || (c == C_WR) || (c == C_RDA) || (c == C_WRA);
  endfunction

  function automatic logic cmd_is_write(sdm_cmd_e c);
    return (c == C_WR) || (c == C_WRA);
  endfunction

  function automatic logic cmd_is_auto(sdm_cmd_e c);
    return (c == C_RDA) || (c == C_WRA);
  endfunction

  // burst length minus one, from the 2-bit select
  function automatic logic [2:0] burst_mask(logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // column of a beat: upper bits fixed, low bits count modulo the burst length
  function automatic logic [7:0] burst_col(logic [7:0] start, logic [2:0] beat,
                                           logic [2:0] mask);
    logic [7:0] m;
    m = {5'b0, mask};
    return (start & ~m) | ((start + {5'b0, beat}) & m);
  endfunction

endpackage

// File: rtl/sdm_bank_tracker.sv
module sdm_bank_tracker
  import sdm_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROWS  = 4,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  sdm_cmd_e                      cmd,
  input  logic [BANK_W-1:0]             bank,
  input  logic [ROW_W-1:0]              row,
  input  logic                          close_evt,
  input  logic [BANK_W-1:0]             close_bank,
  output logic [BANKS-1:0]              open_vec,
  output logic [BANKS-1:0][ROW_W-1:0]   open_row,
  output logic [ROW_W-1:0]              ref_row,
  output logic                          err,
  output logic                          rw_ok
);

  logic act_ok, act_bad, rw_bad, tgt_open;

  assign tgt_open = open_vec[bank];
  assign act_ok   = (cmd == C_ACT) && !tgt_open;
  assign act_bad  = (cmd == C_ACT) &&  tgt_open;
  assign rw_ok    = cmd_is_rw(cmd) &&  tgt_open;
  assign rw_bad   = cmd_is_rw(cmd) && !tgt_open;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;

    assign hit = (bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (cmd == C_PALL || cmd == C_REF) begin
        open_q <= 1'b0;
      end else if (cmd == C_PRE && hit) begin
        open_q <= 1'b0;
      end else if (act_ok && hit) begin
        open_q <= 1'b1;
        row_q  <= row;
      end else if (close_evt && close_bank == BANK_W'(b)) begin
        open_q <= 1'b0;
      end
    end

    assign open_vec[b] = open_q;
    assign open_row[b] = row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row <= '0;
      err     <= 1'b0;
    end else begin
      err <= act_bad || rw_bad;
      if (cmd == C_REF)
        ref_row <= (ref_row == ROW_W'(ROWS - 1)) ? '0 : ref_row + 1'b1;
    end
  end

endmodule

// File: rtl/sdm_burst_engine.sv
module sdm_burst_engine
  import sdm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ld_write,
  input  logic              ld_auto,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [COL_W-1:0]  ld_col,
  input  logic [2:0]        ld_mask,
  output logic              act,
  output logic              is_wr,
  output logic [BANK_W-1:0] cur_bank,
  output logic [ROW_W-1:0]  cur_row,
  output logic [COL_W-1:0]  cur_col,
  output logic              last,
  output logic              auto_done
);

  logic              act_q, wr_q, auto_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  start_q;
  logic [2:0]        mask_q, idx_q;

  assign act       = act_q;
  assign is_wr     = wr_q;
  assign cur_bank  = bank_q;
  assign cur_row   = row_q;
  assign cur_col   = COL_W'(burst_col(8'(start_q), idx_q, mask_q));
  assign last      = (idx_q == mask_q);
  assign auto_done = act_q && last && auto_q && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      auto_q  <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      start_q <= '0;
      mask_q  <= '0;
      idx_q   <= '0;
    end else if (load) begin
      // a write moves beat 0 in the command cycle itself
      act_q   <= !(ld_write && ld_mask == 3'd0);
      wr_q    <= ld_write;
      auto_q  <= ld_auto;
      bank_q  <= ld_bank;
      row_q   <= ld_row;
      start_q <= ld_col;
      mask_q  <= ld_mask;
      idx_q   <= ld_write ? 3'd1 : 3'd0;
    end else if (act_q) begin
      if (last) act_q <= 1'b0;
      else      idx_q <= idx_q + 3'd1;
    end
  end

endmodule

// File: rtl/sdm_store.sv
module sdm_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int NBYTE = DW / 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [NBYTE-1:0] wbe,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < NBYTE; i++)
        if (wbe[i]) mem[waddr][i*8 +: 8] <= wdata[i*8 +: 8];
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdm_read_pipe.sv
module sdm_read_pipe #(
  parameter int DW  = 64,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic [LAT-1:0] v_q;
  logic [DW-1:0]  d_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int s = 1; s < LAT; s++) d_q[s] <= d_q[s-1];
  end

  assign out_valid = v_q[LAT-1];
  assign out_data  = d_q[LAT-1];

endmodule

// File: rtl/sdram_bank_model.sv
module sdram_bank_model
  import sdm_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int ROWS     = 4,
  parameter int COLS     = 16,
  parameter int DW       = 64,
  parameter int READ_LAT = 3,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int NBYTE  = DW / 8,
  localparam int DEPTH  = BANKS * ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bl_code,
  input  logic [DW-1:0]     wdata,
  input  logic [NBYTE-1:0]  wbe,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              err,
  output logic [ROW_W-1:0]  ref_row
);

  sdm_cmd_e cmd_e;
  assign cmd_e = sdm_cmd_e'(cmd);

  // named internal events
  logic [BANKS-1:0]            open_vec;
  logic [BANKS-1:0][ROW_W-1:0] open_row;
  logic                        rw_ok, wr_now, wr_auto_now;
  logic                        close_evt;
  logic [BANK_W-1:0]           close_bank;
  logic                        eng_act, eng_wr, eng_last, eng_auto_done;
  logic [BANK_W-1:0]           eng_bank;
  logic [ROW_W-1:0]            eng_row;
  logic [COL_W-1:0]            eng_col;
  logic                        rd_beat, wr_beat;
  logic [2:0]                  ld_mask;
  logic [ROW_W-1:0]            ld_row;
  logic [COL_W-1:0]            ld_col;
  logic                        st_we;
  logic [BANK_W+ROW_W+COL_W-1:0] st_waddr, st_raddr;
  logic [DW-1:0]               st_rdata;

  assign ld_mask     = burst_mask(bl_code);
  assign ld_row      = open_row[bank];
  assign ld_col      = addr[COL_W-1:0];
  assign wr_now      = rw_ok && cmd_is_write(cmd_e);
  assign wr_auto_now = wr_now && cmd_is_auto(cmd_e) && (ld_mask == 3'd0);
  assign close_evt   = eng_auto_done || wr_auto_now;
  assign close_bank  = wr_auto_now ? bank : eng_bank;
  assign rd_beat     = eng_act && !eng_wr;
  assign wr_beat     = eng_act &&  eng_wr;

  sdm_bank_tracker #(.BANKS(BANKS), .ROWS(ROWS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd_e),
    .bank       (bank),
    .row        (addr[ROW_W-1:0]),
    .close_evt  (close_evt),
    .close_bank (close_bank),
    .open_vec   (open_vec),
    .open_row   (open_row),
    .ref_row    (ref_row),
    .err        (err),
    .rw_ok      (rw_ok)
  );

  sdm_burst_engine #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rw_ok),
    .ld_write  (cmd_is_write(cmd_e)),
    .ld_auto   (cmd_is_auto(cmd_e)),
    .ld_bank   (bank),
    .ld_row    (ld_row),
    .ld_col    (ld_col),
    .ld_mask   (ld_mask),
    .act       (eng_act),
    .is_wr     (eng_wr),
    .cur_bank  (eng_bank),
    .cur_row   (eng_row),
    .cur_col   (eng_col),
    .last      (eng_last),
    .auto_done (eng_auto_done)
  );

  // a newly accepted write owns the write port over a running write beat
  assign st_we    = wr_now || wr_beat;
  assign st_waddr = wr_now ? {bank, ld_row, ld_col} : {eng_bank, eng_row, eng_col};
  assign st_raddr = {eng_bank, eng_row, eng_col};

  sdm_store #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (wdata),
    .wbe   (wbe),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  sdm_read_pipe #(.DW(DW), .LAT(READ_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_beat),
    .in_data   (st_rdata),
    .out_valid (rvalid),
    .out_data  (rdata)
  );

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker
  import sdm_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROWS  = 4,
  parameter int LAT   = 3,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic [BANKS-1:0]  open_vec,
  input logic [ROW_W-1:0]  ref_row,
  input logic              err,
  input logic              rd_beat,
  input logic              rvalid
);

  AST_ACT_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && open_vec[bank]) |=> err); // R2

  AST_RW_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_is_rw(sdm_cmd_e'(cmd)) && !open_vec[bank]) |=> err); // R5

  AST_PALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PALL) |=> (open_vec == '0)); // R3

  AST_REF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |=> (open_vec == '0)); // R4

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |=> (ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ?
                                    '0 : $past(ref_row) + 1'b1))); // R4

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == $past(rd_beat, LAT)); // R8

  AST_ACT_NO_EXTRA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && !open_vec[bank]) |=> open_vec[$past(bank)]); // R1

endmodule

bind sdram_bank_model sdm_checker #(.BANKS(BANKS), .ROWS(ROWS), .LAT(READ_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .bank     (bank),
  .open_vec (open_vec),
  .ref_row  (ref_row),
  .err      (err),
  .rd_beat  (rd_beat),
  .rvalid   (rvalid)
);

// File: tb/sdram_bank_model_tb.sv
module sdram_bank_model_tb;

  localparam int BANKS = 4;
  localparam int ROWS  = 4;
  localparam int COLS  = 16;
  localparam int LAT   = 3;

  logic        clk, rst_n;
  logic [3:0]  cmd;
  logic [1:0]  bank;
  logic [3:0]  addr;
  logic [1:0]  bl_code;
  logic [63:0] wdata;
  logic [7:0]  wbe;
  logic [63:0] rdata;
  logic        rvalid, err;
  logic [1:0]  ref_row;

  sdram_bank_model #(.BANKS(BANKS), .ROWS(ROWS), .COLS(COLS), .DW(64), .READ_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr), .bl_code(bl_code),
    .wdata(wdata), .wbe(wbe), .rdata(rdata), .rvalid(rvalid), .err(err), .ref_row(ref_row)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] sh_mem [BANKS][ROWS][COLS];
  bit          sh_open [BANKS];
  int          sh_row [BANKS];
  int          sh_ref = 0;
  logic        seen_err;
  logic [63:0] mon_e;
  string       mon_t;

  task automatic check(bit ok, string tag, logic [63:0] act_v, logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [63:0] mk(int s, int i);
    return {32'(s), 32'h0BEA_0000 | 32'(i)};
  endfunction

  function automatic int bcol(int start, int beat, int bl);
    return start - (start % bl) + ((start % bl) + beat) % bl;
  endfunction

  // monitor: pops the scoreboard as beats appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read beat", rdata, 64'h0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(rdata === mon_e, mon_t, rdata, mon_e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      cmd = 4'd0;
    end
  endtask

  task automatic issue(int c, int b, int a, int blc, logic [63:0] wd);
    @(negedge clk);
    cmd = 4'(c); bank = 2'(b); addr = 4'(a); bl_code = 2'(blc); wdata = wd; wbe = 8'hFF;
  endtask

  task automatic push_rd(int b, int col, int blc, int nbeats, string tag);
    int bl = 1 << blc;
    for (int k = 0; k < nbeats; k++) begin
      exp_q.push_back(sh_mem[b][sh_row[b]][bcol(col, k, bl)]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic act(int b, int row, string tag);
    bit was_open = sh_open[b];
    issue(1, b, row, 0, 64'h0);
    @(negedge clk); cmd = 4'd0;
    check(err === was_open, tag, 64'(err), 64'(was_open));
    if (!was_open) begin sh_open[b] = 1; sh_row[b] = row; end
  endtask

  task automatic simple(int c, int b, string tag);
    issue(c, b, 0, 0, 64'h0);
    @(negedge clk); cmd = 4'd0;
    check(err === 1'b0, tag, 64'(err), 64'h0);
    if (c == 6) sh_open[b] = 0;
    else for (int i = 0; i < BANKS; i++) sh_open[i] = 0;
    if (c == 8) begin
      sh_ref = (sh_ref + 1) % ROWS;
      check(ref_row === 2'(sh_ref), tag, 64'(ref_row), 64'(sh_ref));
    end
  endtask

  task automatic wr(int b, int col, int blc, bit au, int seed, logic [7:0] be, string tag);
    int bl = 1 << blc;
    bit ok = sh_open[b];
    issue(au ? 5 : 3, b, col, blc, mk(seed, 0));
    wbe = be;
    for (int i = 1; i < ((bl > 1) ? bl : 2); i++) begin
      @(negedge clk); cmd = 4'd0;
      if (i < bl) wdata = mk(seed, i);
      if (i == 1) seen_err = err;
    end
    @(negedge clk);
    check(seen_err === !ok, tag, 64'(seen_err), 64'(!ok));
    if (ok) begin
      for (int k = 0; k < bl; k++)
        for (int j = 0; j < 8; j++)
          if (be[j]) sh_mem[b][sh_row[b]][bcol(col, k, bl)][j*8 +: 8] = mk(seed, k)[j*8 +: 8];
      if (au) sh_open[b] = 0;
    end
  endtask

  task automatic rd(int b, int col, int blc, bit au, string tag);
    int bl = 1 << blc;
    bit ok = sh_open[b];
    issue(au ? 4 : 2, b, col, blc, 64'h0);
    if (ok) push_rd(b, col, blc, bl, tag);
    @(negedge clk); cmd = 4'd0;
    seen_err = err;
    check(seen_err === !ok, tag, 64'(seen_err), 64'(!ok));
    idle(bl + LAT + 1);
    if (ok && au) sh_open[b] = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R8 run did not finish) actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int first;
    rst_n = 0; cmd = 0; bank = 0; addr = 0; bl_code = 0; wdata = 0; wbe = 8'hFF;
    for (int i = 0; i < BANKS; i++) begin sh_open[i] = 0; sh_row[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check(rvalid === 1'b0, "R12 rvalid after reset", 64'(rvalid), 64'h0);
    check(err === 1'b0, "R12 err after reset", 64'(err), 64'h0);
    check(ref_row === 2'd0, "R12 ref_row after reset", 64'(ref_row), 64'h0);
    rd(0, 0, 2, 0, "R12 bank closed after reset");

    // R1 independent banks
    act(0, 1, "R1 activate bank0");
    act(1, 2, "R1 activate bank1");
    wr(0, 0, 3, 0, 100, 8'hFF, "R9 write bank0 bl8");
    wr(0, 8, 3, 0, 150, 8'hFF, "R9 write bank0 upper");
    wr(1, 0, 3, 0, 200, 8'hFF, "R1 write bank1 bl8");
    rd(0, 0, 3, 0, "R1 read bank0 bl8");
    rd(1, 0, 3, 0, "R1 read bank1 bl8");

    // R6 / R7 lengths and wrap order
    rd(0, 6, 2, 0, "R7 wrap bl4 start 6");
    rd(0, 3, 1, 0, "R7 wrap bl2 start 3");
    rd(0, 13, 3, 0, "R7 wrap bl8 start 13");
    rd(0, 5, 0, 0, "R6 single beat");
    rd(1, 2, 1, 0, "R6 two beats");

    // R9 byte enables
    wr(0, 9, 1, 0, 300, 8'hA5, "R9 partial byte enables");
    rd(0, 8, 3, 0, "R9 merged bytes");

    // R2 activate on open bank
    act(0, 3, "R2 activate on open bank");
    rd(0, 0, 2, 0, "R2 open row unchanged");

    // R5 closed bank, no abort
    rd(2, 0, 2, 0, "R5 read closed bank");
    wr(2, 0, 1, 0, 900, 8'hFF, "R5 write closed bank");
    issue(2, 0, 0, 2, 64'h0);
    push_rd(0, 0, 2, 4, "R5 burst not cut by bad read");
    issue(2, 2, 0, 2, 64'h0);
    @(negedge clk); cmd = 4'd0;
    check(err === 1'b1, "R5 bad read during burst", 64'(err), 64'h1);
    idle(10);

    // R8 latency
    issue(2, 1, 5, 0, 64'h0);
    push_rd(1, 5, 0, 1, "R8 single beat data");
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); cmd = 4'd0;
      if (rvalid && first == 0) first = i;
    end
    check(first == 4, "R8 first beat latency", 64'(first), 64'd4);
    idle(4);

    // R11 read cut short by read
    issue(2, 0, 0, 3, 64'h0);
    push_rd(0, 0, 3, 2, "R11 aborted read head");
    @(negedge clk); cmd = 4'd0;
    issue(2, 1, 4, 2, 64'h0);
    push_rd(1, 4, 2, 4, "R11 new read after abort");
    @(negedge clk); cmd = 4'd0;
    idle(12);

    // R11 write cut short by write
    issue(3, 1, 0, 3, mk(400, 0));
    @(negedge clk); cmd = 4'd0; wdata = mk(400, 1);
    issue(3, 1, 8, 1, mk(500, 0));
    @(negedge clk); cmd = 4'd0; wdata = mk(500, 1);
    @(negedge clk);
    sh_mem[1][2][0] = mk(400, 0); sh_mem[1][2][1] = mk(400, 1);
    sh_mem[1][2][8] = mk(500, 0); sh_mem[1][2][9] = mk(500, 1);
    rd(1, 0, 3, 0, "R11 write cut short");
    rd(1, 8, 1, 0, "R11 new write landed");

    // R3 precharge
    simple(6, 0, "R3 precharge bank0");
    rd(0, 0, 0, 0, "R3 read after precharge");
    simple(6, 0, "R3 precharge on closed bank");
    rd(1, 0, 0, 0, "R3 other bank still open");
    simple(7, 0, "R3 precharge all");
    rd(1, 0, 0, 0, "R3 bank1 closed by precharge all");

    // R4 refresh
    act(2, 1, "R4 activate bank2");
    act(3, 0, "R4 activate bank3");
    simple(8, 0, "R4 refresh one");
    rd(2, 0, 0, 0, "R4 bank2 closed by refresh");
    rd(3, 0, 0, 0, "R4 bank3 closed by refresh");
    simple(8, 0, "R4 refresh two");
    simple(8, 0, "R4 refresh three");
    simple(8, 0, "R4 refresh wrap");

    // R10 auto precharge
    act(3, 2, "R10 open bank3");
    wr(3, 0, 2, 1, 600, 8'hFF, "R10 write-auto bl4");
    rd(3, 0, 2, 0, "R10 closed after write-auto");
    act(3, 2, "R10 reopen bank3");
    rd(3, 0, 2, 1, "R10 read-auto data");
    rd(3, 0, 0, 0, "R10 closed after read-auto");
    act(3, 2, "R10 reopen again");
    wr(3, 5, 0, 1, 700, 8'hFF, "R10 write-auto single beat");
    rd(3, 5, 0, 0, "R10 closed after single write-auto");
    act(3, 2, "R10 reopen for readback");
    rd(3, 5, 0, 0, "R10 single beat readback");
    rd(3, 1, 1, 0, "R10 plain read keeps row");
    rd(3, 1, 1, 0, "R10 row still open");

    idle(10);
    check(exp_q.size() == 0, "R8 all expected beats delivered", 64'(exp_q.size()), 64'h0);
    summary();
    done = 1;
    $finish;
  end

endmodule